// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Register File

This block holds the programmable state of a 32-input interrupt router. Software reaches that state through two words on a plain 32-bit memory-mapped bus. The first word is an index register. The second is a data window that reads and writes whichever internal register the index points at.

Behind the window sit four kinds of register:
- a 4-bit identifier;
- a read-only version word;
- a read-only arbitration word that mirrors the identifier;
- one 64-bit redirection entry per input, each split across two consecutive indices.

Two bits in every entry belong to the delivery engine that sits next to this block. One is the remote-pending flag and the other is the delivery-status flag. Software writes never alter them. The delivery engine sets and clears remote-pending through strobes and drives delivery-status as a live level.

Every entry is exported in parallel to the delivery engine, so no extra access is needed to read it. When a write alters a routing-relevant field, the block raises a one-cycle change flag. Every table write also raises a one-cycle rewrite event that carries the pin number. This lets the engine re-evaluate that pin.

Top module: `irq_route_regfile`

## Requirements
- R1: Only bus offsets 0x00 (index) and 0x10 (window) respond, and only when all four byte enables are set. Any other access reads 0x00000000 and a write of that kind changes no state.
- R2: The index register reads back all 32 bits last written to it. Only its bits 7:0 choose the internal register behind the window.
- R3: Index 0 is the identifier. A write stores wdata[27:24], and a read returns the identifier in bits 27:24 with all other bits zero. Index 2 reads the same word. Writes to indices 1 and 2 have no effect.
- R4: Index 1 reads ((pins − 1) << 16) | 0x11, which is 0x001F0011 for 32 pins.
- R5: Pin p's entry bits 31:0 sit at index 0x10+2p and bits 63:32 at index 0x11+2p. Indices outside 0x10..0x4F other than 0, 1 and 2 read zero, and writes to them change no entry and raise no event.
- R6: After reset, the index register and the identifier are 0 and every entry holds 0x00010000_00010000, with the mask bit (bit 16) set.
- R7: Entry bit 12 (delivery status) equals the pin's dlv_status input as registered one cycle earlier. Entry bit 14 (remote pending) is set by rp_set and cleared by rp_clr. Window writes never alter either bit, and every other bit of the addressed half takes the written data.
- R8: A window write after which entry bit 15 (trigger mode, 1 = level) is 0 clears bit 14 in the same update. A write that leaves bit 15 at 1 keeps bit 14.
- R9: cfg_changed is high for exactly the cycle after a table write that changes any entry bit other than bit 16 (mask) and bit 13 (polarity), including a bit-14 clear caused by R8.
- R10: rewrite_evt is high for the cycle after every table write, with rewrite_pin giving the written pin. It stays low otherwise.
- R11: ent_flat[64p+63:64p] carries pin p's entry at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset within the block |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational in the access cycle |
| rp_set | input | 32 | Per-pin strobe setting remote pending |
| rp_clr | input | 32 | Per-pin strobe clearing remote pending |
| dlv_status | input | 32 | Per-pin delivery-status level |
| ent_flat | output | 2048 | All entries, pin p at bits 64p+63:64p |
| cfg_changed | output | 1 | One-cycle pulse: routing field altered |
| rewrite_evt | output | 1 | One-cycle pulse: an entry was written |
| rewrite_pin | output | 5 | Pin number of the write that raised rewrite_evt |

## Verification
The hardest state to reach from the ports is a level-mode entry that holds remote pending and is then rewritten to edge mode. In that write the read-only protection and the pending clear interact, and the change flag must see the cleared bit.

The stimulus gets there by first writing a level configuration, then pulsing rp_set on that pin, and then rewriting the low half several times. Only the mask and polarity change first, which must raise no change flag. Then the trigger bit drops, which must clear the pending bit and raise the flag. The delivery-status level is held high throughout, so the protection of both read-only bits is checked against live values.

// File: rtl/irq_rr_pkg.sv
// Shared constants for the redirection register file: entry bit positions,
// reset image, read-only and routing-relevant masks, bus offsets and indices.
package irq_rr_pkg;
    localparam int ENT_W   = 64;
    localparam int B_DLV   = 12;   // delivery status, driven by engine
    localparam int B_POL   = 13;   // input polarity
    localparam int B_RPEND = 14;   // remote pending, driven by engine
    localparam int B_TRIG  = 15;   // 1 = level, 0 = edge
    localparam int B_MASK  = 16;   // 1 = masked

    localparam logic [ENT_W-1:0] ENT_RST  = 64'h0001_0000_0001_0000;
    localparam logic [ENT_W-1:0] RO_MASK  = (64'h1 << B_DLV) | (64'h1 << B_RPEND);
    localparam logic [ENT_W-1:0] CFG_MASK = ~((64'h1 << B_MASK) | (64'h1 << B_POL));

    localparam logic [7:0] OFS_SEL = 8'h00;
    localparam logic [7:0] OFS_WIN = 8'h10;
    localparam logic [7:0] IDX_ID  = 8'd0;
    localparam logic [7:0] IDX_VER = 8'd1;
    localparam logic [7:0] IDX_ARB = 8'd2;
endpackage

// File: rtl/irq_regsel_decode.sv
// Decodes the 8-bit register index into a target class and, for the table,
// a pin number and half select. Assumes the table is contiguous from TBL_BASE.
module irq_regsel_decode
    import irq_rr_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int TBL_BASE = 16,
    parameter int PIN_W    = 5
) (
    input  logic [7:0]       idx,
    output logic             is_id,
    output logic             is_ver,
    output logic             is_arb,
    output logic             is_tbl,
    output logic [PIN_W-1:0] pin,
    output logic             hi
);
    localparam int TBL_END = TBL_BASE + 2 * NUM_PINS;

    logic [8:0] rel;

    // Classify the index and split table offsets into pin and half.
    always_comb begin
        rel    = {1'b0, idx} - 9'(TBL_BASE);
        is_id  = (idx == IDX_ID);
        is_ver = (idx == IDX_VER);
        is_arb = (idx == IDX_ARB);
        is_tbl = (int'(idx) >= TBL_BASE) && (int'(idx) < TBL_END);
        pin    = PIN_W'(rel >> 1);
        hi     = rel[0];
    end
endmodule

// File: rtl/irq_rte_entry.sv
// One 64-bit redirection entry. Merges software writes around the two
// engine-owned bits, clears remote pending on edge mode after a write and
// reports routing-relevant changes. Assumes wr_lo and wr_hi are never both set.
module irq_rte_entry
    import irq_rr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [31:0]      wdata,
    input  logic             rp_set,
    input  logic             rp_clr,
    input  logic             dlv_stat,
    output logic [ENT_W-1:0] q,
    output logic             cfg_chg
);
    logic [ENT_W-1:0] base, wmask, merged, nxt;
    logic             wr_any;

    // Apply engine updates, then the write merge, then the edge-mode clear.
    always_comb begin
        wr_any = wr_lo | wr_hi;
        base   = q;
        base[B_DLV] = dlv_stat;
        if (rp_set)      base[B_RPEND] = 1'b1;
        else if (rp_clr) base[B_RPEND] = 1'b0;
        wmask  = {{32{wr_hi}}, {32{wr_lo}}} & ~RO_MASK;
        merged = (base & ~wmask) | ({wdata, wdata} & wmask);
        nxt    = merged;
        if (wr_any && !merged[B_TRIG] && merged[B_RPEND])
            nxt[B_RPEND] = 1'b0;
        cfg_chg = wr_any && (|((base ^ nxt) & CFG_MASK));
    end

    // Entry storage with masked reset image.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= ENT_RST;
        else        q <= nxt;
    end

    // After any write, an edge-mode entry never shows remote pending.
    assert_edge_clears_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo || wr_hi) |=> !(!q[B_TRIG] && q[B_RPEND]));

    // Delivery status tracks the engine input one cycle later.
    assert_status_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q[B_DLV] == $past(dlv_stat)));

    // Without writes or engine strobes, remote pending holds.
    assert_pend_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi && !rp_set && !rp_clr) |=> (q[B_RPEND] == $past(q[B_RPEND])));
endmodule

// File: rtl/irq_route_regfile.sv
// Register file of an interrupt router reached through an index/window pair.
// Holds identifier, version, arbitration words and NUM_PINS redirection
// entries; exports entries and emits change and rewrite pulses.
// Assumes single-cycle accesses with no wait states.
module irq_route_regfile
    import irq_rr_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int TBL_BASE = 16,
    parameter int ID_W     = 4,
    parameter int ID_LSB   = 24,
    localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_we,
    input  logic [7:0]                bus_addr,
    input  logic [3:0]                bus_be,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_PINS-1:0]       rp_set,
    input  logic [NUM_PINS-1:0]       rp_clr,
    input  logic [NUM_PINS-1:0]       dlv_status,
    output logic [NUM_PINS*ENT_W-1:0] ent_flat,
    output logic                      cfg_changed,
    output logic                      rewrite_evt,
    output logic [PIN_W-1:0]          rewrite_pin
);
    localparam logic [31:0] VER_WORD = (32'(NUM_PINS - 1) << 16) | 32'h11;

    logic [31:0]      sel_q;
    logic [ID_W-1:0]  id_q;
    logic             full, sel_acc, win_acc, tbl_wr;
    logic             is_id, is_ver, is_arb, is_tbl, hi;
    logic [PIN_W-1:0] pin;
    logic [ENT_W-1:0] ent_q [NUM_PINS];
    logic [NUM_PINS-1:0] cfg_chg_v;

    // Qualify an access: full word at one of the two decoded offsets.
    always_comb begin
        full    = bus_sel && (bus_be == 4'hF);
        sel_acc = full && (bus_addr == OFS_SEL);
        win_acc = full && (bus_addr == OFS_WIN);
        tbl_wr  = win_acc && bus_we && is_tbl;
    end

    irq_regsel_decode #(
        .NUM_PINS (NUM_PINS),
        .TBL_BASE (TBL_BASE),
        .PIN_W    (PIN_W)
    ) decode_i (
        .idx    (sel_q[7:0]),
        .is_id  (is_id),
        .is_ver (is_ver),
        .is_arb (is_arb),
        .is_tbl (is_tbl),
        .pin    (pin),
        .hi     (hi)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
        logic wr_lo_i, wr_hi_i;
        assign wr_lo_i = tbl_wr && !hi && (pin == PIN_W'(i));
        assign wr_hi_i = tbl_wr &&  hi && (pin == PIN_W'(i));
        irq_rte_entry ent_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (wr_lo_i),
            .wr_hi    (wr_hi_i),
            .wdata    (bus_wdata),
            .rp_set   (rp_set[i]),
            .rp_clr   (rp_clr[i]),
            .dlv_stat (dlv_status[i]),
            .q        (ent_q[i]),
            .cfg_chg  (cfg_chg_v[i])
        );
        assign ent_flat[ENT_W*i +: ENT_W] = ent_q[i];
    end

    // Index register: plain 32-bit storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                 sel_q <= '0;
        else if (sel_acc && bus_we) sel_q <= bus_wdata;
    end

    // Identifier: takes its field from the write data on index 0 only.
    always_ff @(posedge clk) begin
        if (!rst_n)                          id_q <= '0;
        else if (win_acc && bus_we && is_id) id_q <= bus_wdata[ID_LSB +: ID_W];
    end

    // Event pulses, one cycle after the write that causes them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_changed <= 1'b0;
            rewrite_evt <= 1'b0;
            rewrite_pin <= '0;
        end else begin
            cfg_changed <= |cfg_chg_v;
            rewrite_evt <= tbl_wr;
            rewrite_pin <= tbl_wr ? pin : '0;
        end
    end

    // Read mux: zero for every access that is not decoded.
    always_comb begin
        bus_rdata = '0;
        if (sel_acc && !bus_we) begin
            bus_rdata = sel_q;
        end else if (win_acc && !bus_we) begin
            if (is_id || is_arb) bus_rdata = 32'(id_q) << ID_LSB;
            else if (is_ver)     bus_rdata = VER_WORD;
            else if (is_tbl)     bus_rdata = hi ? ent_q[pin][63:32] : ent_q[pin][31:0];
        end
    end

    // Partial-width reads always return zero.
    assert_partial_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_be != 4'hF) |-> (bus_rdata == 32'h0));

    // A change flag only accompanies a rewrite event.
    assert_cfg_with_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_changed |-> rewrite_evt);

    // A rewrite event is always preceded by a full-width window write.
    assert_evt_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rewrite_evt |-> $past(bus_sel && bus_we && bus_be == 4'hF && bus_addr == OFS_WIN));

    // The index register only moves on a full write to offset 0.
    assert_sel_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_we && bus_be == 4'hF && bus_addr == OFS_SEL) |=> $stable(sel_q));
endmodule

// File: tb/irq_route_regfile_tb_top.sv
`timescale 1ns/1ps
module irq_route_regfile_tb_top;
    localparam int N  = 32;
    localparam int NV = 34;
    localparam logic [63:0] RST_ENT = 64'h0001_0000_0001_0000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]       bus_addr = '0;
    logic [3:0]       bus_be = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [N-1:0]     rp_set = '0, rp_clr = '0, dlv_status = '0;
    logic [N*64-1:0]  ent_flat;
    logic             cfg_changed, rewrite_evt;
    logic [4:0]       rewrite_pin;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    irq_route_regfile dut_i (
        .clk (clk), .rst_n (rst_n),
        .bus_sel (bus_sel), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_be (bus_be), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .rp_set (rp_set), .rp_clr (rp_clr), .dlv_status (dlv_status),
        .ent_flat (ent_flat), .cfg_changed (cfg_changed),
        .rewrite_evt (rewrite_evt), .rewrite_pin (rewrite_pin)
    );

    // {req[3:0], we, addr[7:0], be[3:0], wdata[31:0], expected read[31:0]}
    localparam logic [80:0] VECS [NV] = '{
        {4'd6, 1'b0, 8'h00, 4'hF, 32'h0,        32'h0},        // R6 index resets to 0
        {4'd2, 1'b1, 8'h00, 4'hF, 32'hABCD1203, 32'h0},        // R2
        {4'd2, 1'b0, 8'h00, 4'hF, 32'h0,        32'hABCD1203}, // R2 full readback
        {4'd5, 1'b0, 8'h10, 4'hF, 32'h0,        32'h0},        // R5 index 0x03 unused
        {4'd4, 1'b1, 8'h00, 4'hF, 32'h1,        32'h0},        // R4
        {4'd4, 1'b0, 8'h10, 4'hF, 32'h0,        32'h001F0011}, // R4 version
        {4'd1, 1'b0, 8'h10, 4'h3, 32'h0,        32'h0},        // R1 partial read
        {4'd1, 1'b0, 8'h10, 4'hF, 32'h0,        32'h001F0011}, // R1 full read works
        {4'd3, 1'b1, 8'h00, 4'hF, 32'h0,        32'h0},        // R3
        {4'd3, 1'b1, 8'h10, 4'hF, 32'h05000000, 32'h0},        // R3 id = 5
        {4'd3, 1'b0, 8'h10, 4'hF, 32'h0,        32'h05000000}, // R3
        {4'd3, 1'b1, 8'h00, 4'hF, 32'h2,        32'h0},        // R3
        {4'd3, 1'b0, 8'h10, 4'hF, 32'h0,        32'h05000000}, // R3 arbitration mirrors
        {4'd3, 1'b1, 8'h10, 4'hF, 32'hFFFFFFFF, 32'h0},        // R3 write ignored
        {4'd3, 1'b0, 8'h10, 4'hF, 32'h0,        32'h05000000}, // R3
        {4'd3, 1'b1, 8'h00, 4'hF, 32'h1,        32'h0},        // R3
        {4'd3, 1'b1, 8'h10, 4'hF, 32'h0,        32'h0},        // R3 version write ignored
        {4'd3, 1'b0, 8'h10, 4'hF, 32'h0,        32'h001F0011}, // R3
        {4'd1, 1'b1, 8'h04, 4'hF, 32'h12,       32'h0},        // R1 bad offset write
        {4'd1, 1'b1, 8'h00, 4'h1, 32'h77,       32'h0},        // R1 partial write
        {4'd1, 1'b0, 8'h00, 4'hF, 32'h0,        32'h00000001}, // R1 index unchanged
        {4'd1, 1'b0, 8'h14, 4'hF, 32'h0,        32'h0},        // R1 bad offset read
        {4'd6, 1'b1, 8'h00, 4'hF, 32'h10,       32'h0},        // R6
        {4'd6, 1'b0, 8'h10, 4'hF, 32'h0,        32'h00010000}, // R6 pin0 low
        {4'd6, 1'b1, 8'h00, 4'hF, 32'h4F,       32'h0},        // R6
        {4'd6, 1'b0, 8'h10, 4'hF, 32'h0,        32'h00010000}, // R6 pin31 high
        {4'd5, 1'b1, 8'h00, 4'hF, 32'h50,       32'h0},        // R5
        {4'd5, 1'b0, 8'h10, 4'hF, 32'h0,        32'h0},        // R5 past table end
        {4'd5, 1'b1, 8'h10, 4'hF, 32'hDEADBEEF, 32'h0},        // R5 ignored write
        {4'd5, 1'b1, 8'h00, 4'hF, 32'h0F,       32'h0},        // R5
        {4'd5, 1'b0, 8'h10, 4'hF, 32'h0,        32'h0},        // R5 below table
        {4'd3, 1'b1, 8'h00, 4'hF, 32'h0,        32'h0},        // R3
        {4'd3, 1'b1, 8'h10, 4'hF, 32'hF3000000, 32'h0},        // R3 only bits 27:24
        {4'd3, 1'b0, 8'h10, 4'hF, 32'h0,        32'h03000000}  // R3
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_idx(input logic [7:0] idx, output logic [31:0] d);
        bus_wr(8'h00, 4'hF, {24'h0, idx});
        bus_rd(8'h10, 4'hF, d);
    endtask

    task automatic wr_idx(input logic [7:0] idx, input logic [31:0] d);
        bus_wr(8'h00, 4'hF, {24'h0, idx});
        bus_wr(8'h10, 4'hF, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0]     rd;
        logic [N*64-1:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int p = 0; p < N; p++) chk("R6 R11 reset entry", ent_flat[64*p +: 64], RST_ENT);
        chk("R10 no event after reset", {63'h0, rewrite_evt}, 64'h0);
        chk("R9 no change after reset", {63'h0, cfg_changed}, 64'h0);

        for (int v = 0; v < NV; v++) begin
            if (VECS[v][76]) begin
                bus_wr(VECS[v][75:68], VECS[v][67:64], VECS[v][63:32]);
            end else begin
                bus_rd(VECS[v][75:68], VECS[v][67:64], rd);
                chk($sformatf("R%0d vector %0d", VECS[v][80:77], v), {32'h0, rd}, {32'h0, VECS[v][31:0]});
            end
        end
        chk("R5 ignored writes leave entries", ent_flat[63:0], RST_ENT);
        chk("R5 ignored writes leave pin31", ent_flat[64*31 +: 64], RST_ENT);

        // R5: out-of-table write raises no event
        bus_wr(8'h00, 4'hF, 32'h50);
        snap = ent_flat;
        bus_wr(8'h10, 4'hF, 32'h12345678);
        chk("R5 no event outside table", {63'h0, rewrite_evt}, 64'h0);
        chk("R5 entries untouched", {63'h0, ent_flat == snap}, 64'h1);

        // R7 R10 R11: low half write around read-only bits
        wr_idx(8'h16, 32'hFFFFFFFF);
        chk("R10 event", {63'h0, rewrite_evt}, 64'h1);
        chk("R10 pin", {59'h0, rewrite_pin}, 64'd3);
        chk("R9 change flag", {63'h0, cfg_changed}, 64'h1);
        @(negedge clk);
        chk("R10 event is one cycle", {63'h0, rewrite_evt}, 64'h0);
        chk("R9 flag is one cycle", {63'h0, cfg_changed}, 64'h0);
        rd_idx(8'h16, rd);
        chk("R7 read-only bits kept", {32'h0, rd}, 64'hFFFFAFFF);
        chk("R11 export pin3 low", {32'h0, ent_flat[64*3 +: 32]}, 64'hFFFFAFFF);

        // R7: delivery status and remote pending from the engine
        @(negedge clk); dlv_status[3] = 1'b1;
        @(negedge clk);
        rd_idx(8'h16, rd);
        chk("R7 status mirrors input", {32'h0, rd}, 64'hFFFFBFFF);
        @(negedge clk); rp_set[3] = 1'b1;
        @(negedge clk); rp_set[3] = 1'b0;
        rd_idx(8'h16, rd);
        chk("R7 pending set by engine", {32'h0, rd}, 64'hFFFFFFFF);

        // R8 R9: level write keeps pending
        wr_idx(8'h16, 32'h00008021);
        chk("R9 vector change flagged", {63'h0, cfg_changed}, 64'h1);
        rd_idx(8'h16, rd);
        chk("R8 level keeps pending", {32'h0, rd}, 64'h0000D021);
        wr_idx(8'h16, 32'h00008021);
        chk("R9 identical write no flag", {63'h0, cfg_changed}, 64'h0);
        chk("R10 identical write event", {63'h0, rewrite_evt}, 64'h1);
        wr_idx(8'h16, 32'h0001A021);
        chk("R9 mask/polarity no flag", {63'h0, cfg_changed}, 64'h0);
        rd_idx(8'h16, rd);
        chk("R7 mask/polarity stored", {32'h0, rd}, 64'h0001F021);
        wr_idx(8'h16, 32'h00002021);
        chk("R9 edge switch flagged", {63'h0, cfg_changed}, 64'h1);
        rd_idx(8'h16, rd);
        chk("R8 edge clears pending", {32'h0, rd}, 64'h00003021);

        // R7: engine clear
        @(negedge clk); rp_set[3] = 1'b1;
        @(negedge clk); rp_set[3] = 1'b0;
        rd_idx(8'h16, rd);
        chk("R7 pending set again", {32'h0, rd}, 64'h00007021);
        @(negedge clk); rp_clr[3] = 1'b1;
        @(negedge clk); rp_clr[3] = 1'b0;
        rd_idx(8'h16, rd);
        chk("R7 pending cleared by engine", {32'h0, rd}, 64'h00003021);

        // R5 R11: high half of pin 3
        wr_idx(8'h17, 32'hAB000000);
        chk("R9 destination change", {63'h0, cfg_changed}, 64'h1);
        chk("R10 high half pin", {59'h0, rewrite_pin}, 64'd3);
        rd_idx(8'h17, rd);
        chk("R5 high half readback", {32'h0, rd}, 64'hAB000000);
        chk("R11 export pin3 high", {32'h0, ent_flat[64*3+32 +: 32]}, 64'hAB000000);

        // R10: last pin
        wr_idx(8'h4E, 32'h00000040);
        chk("R10 last pin number", {59'h0, rewrite_pin}, 64'd31);
        chk("R11 export pin31", ent_flat[64*31 +: 64], 64'h00010000_00000040);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule